// File: doc/BRIEF.md
# Two-Level Halfword Page Map Walker

This block refills one entry of an address translation table. A refill request gives a virtual page number and says which table it is for: the user table or the supervisor table. It also says whether the reference is a write, and whether it is only a query. The walker works out the physical word address of the descriptor. It reads that word over a simple request/acknowledge memory port and picks the half of the word that belongs to the page. It then applies the access rules.

When access is granted, the walker returns an expanded entry. The entry holds the physical page number, a valid flag and a modify flag. The walker also pulses a table write-enable so that the surrounding translation logic can store the entry. When access is refused, it raises a page fault. Each completed walk also produces a fault status word that software can inspect.

Each memory word holds two descriptors. User descriptors sit in one contiguous map off the user base. Supervisor descriptors are spread over three ranges of virtual pages. The middle range is located off the user base, not the supervisor base. In query mode the walker reports extra descriptor bits and leaves the table untouched. A descriptor fetch that returns a non-existent-memory response ends the walk with a hard fault.

Top module: `pmap_walker`

## Requirements
- R1: For a user request, the descriptor word address is user_base + UMAP_OFS + (vpn >> 1), modulo 2^ADDR_W.
- R2: For a supervisor request with vpn below octal 340, the address is sup_base + SLO_OFS + (vpn >> 1).
- R3: For a supervisor request with vpn from octal 340 up to octal 377, the address is user_base + SMID_OFS + ((vpn − octal 340) >> 1).
- R4: For a supervisor request with vpn of octal 400 or higher, the address is sup_base + SHI_OFS + ((vpn − octal 400) >> 1).
- R5: An even vpn takes its descriptor from mem_rdata[35:18], and an odd vpn takes it from mem_rdata[17:0].
- R6: Within the 18-bit descriptor, bit 17 is accessible, bit 16 is writable, bit 15 is software, bit 14 is cacheable, and bits PPN_W-1:0 are the physical page. A walk succeeds (ok=1, fault=0) only when accessible is set and, for a write, writable is also set. Every other case gives ok=0, fault=1.
- R7: On success, entry_valid=1, entry_ppn is the descriptor page, and entry_modify equals the writable bit. On a fault all three are 0.
- R8: After every walk, fsw holds: vpn in bits VPN_W-1:0, user at VPN_W, write at VPN_W+1, accessible at VPN_W+2, and software at VPN_W+4. The software flag is recorded only when accessible is set or the walk is a query.
- R9: For a query walk, fsw also carries writable at VPN_W+3 and cacheable at VPN_W+5, and tbl_we stays 0. A successful non-query walk pulses tbl_we together with done. A non-query walk leaves fsw bits VPN_W+3 and VPN_W+5 at 0.
- R10: If mem_nxm is high with mem_ack, the walk ends with hard=1 (fsw bit VPN_W+6), fault=1, ok=0 and tbl_we=0, and all descriptor-derived flags are 0.
- R11: mem_req stays high, with mem_addr stable, until mem_ack. done is a single-cycle pulse in the cycle after the acknowledge. A request is accepted only while req_ready is high.
- R12: After reset, req_ready=1 and mem_req, done, ok, fault, hard and tbl_we are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Refill request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vpn | input | VPN_W | Virtual page number |
| req_user | input | 1 | 1 = user table, 0 = supervisor table |
| req_write | input | 1 | Write reference |
| req_query | input | 1 | Query only, no table update |
| user_base | input | ADDR_W | User process table base word address |
| sup_base | input | ADDR_W | Supervisor process table base word address |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | ADDR_W | Descriptor word address |
| mem_ack | input | 1 | Read complete |
| mem_rdata | input | 36 | Descriptor pair word |
| mem_nxm | input | 1 | Read hit non-existent memory (with mem_ack) |
| done | output | 1 | Walk finished, one-cycle pulse |
| ok | output | 1 | Access granted |
| fault | output | 1 | Page fault |
| hard | output | 1 | Fault caused by non-existent memory |
| entry_ppn | output | PPN_W | Physical page number of the entry |
| entry_valid | output | 1 | Entry valid |
| entry_modify | output | 1 | Entry writable |
| tbl_we | output | 1 | Store entry into the translation table |
| fsw | output | VPN_W+7 | Fault status word |

## Verification
The bench builds the walker with ADDR_W=16 and PPN_W=8, and keeps VPN_W=9 so that every page number from 0 to 511 can be swept. With that size the full cross-product is small enough to run exhaustively: both tables, every page across the three supervisor ranges, and all four write/query combinations. It places the two bases so that the address sums wrap the 16-bit word address. The memory model returns descriptor words that are computed arithmetically from the address. Across the sweep every combination of the accessible, writable, software and cacheable bits occurs in both halves, and acknowledge delays of 0 to 2 cycles are mixed in.

// File: rtl/pmap_walker.sv
module pmap_walker #(
  parameter int VPN_W     = 9,
  parameter int ADDR_W    = 18,
  parameter int PPN_W     = 9,
  parameter int MID_START = 'o340,
  parameter int HI_START  = 'o400,
  parameter int UMAP_OFS  = 'o200,
  parameter int SLO_OFS   = 'o1000,
  parameter int SMID_OFS  = 'o700,
  parameter int SHI_OFS   = 'o1200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic              req_user,
  input  logic              req_write,
  input  logic              req_query,
  input  logic [ADDR_W-1:0] user_base,
  input  logic [ADDR_W-1:0] sup_base,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [35:0]       mem_rdata,
  input  logic              mem_nxm,
  output logic              done,
  output logic              ok,
  output logic              fault,
  output logic              hard,
  output logic [PPN_W-1:0]  entry_ppn,
  output logic              entry_valid,
  output logic              entry_modify,
  output logic              tbl_we,
  output logic [VPN_W+6:0]  fsw
);

  localparam int HALF_W = 18;
  localparam int A_BIT  = 17;
  localparam int W_BIT  = 16;
  localparam int S_BIT  = 15;
  localparam int C_BIT  = 14;

  typedef enum logic {S_IDLE, S_FETCH} st_t;
  st_t st;

  logic [VPN_W-1:0]  q_vpn;
  logic              q_user, q_write, q_query;
  logic [ADDR_W-1:0] vz, desc_addr;
  logic [HALF_W-1:0] half;
  logic              d_a, d_w, d_s, d_c, take;

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st == S_FETCH);
  assign vz        = ADDR_W'(req_vpn);

  always_comb begin
    if (req_user)
      desc_addr = user_base + ADDR_W'(UMAP_OFS) + (vz >> 1);
    else if (req_vpn < VPN_W'(MID_START))
      desc_addr = sup_base + ADDR_W'(SLO_OFS) + (vz >> 1);
    else if (req_vpn < VPN_W'(HI_START))
      desc_addr = user_base + ADDR_W'(SMID_OFS) + ((vz - ADDR_W'(MID_START)) >> 1);
    else
      desc_addr = sup_base + ADDR_W'(SHI_OFS) + ((vz - ADDR_W'(HI_START)) >> 1);
  end

  assign half = q_vpn[0] ? mem_rdata[HALF_W-1:0] : mem_rdata[2*HALF_W-1:HALF_W];
  assign d_a  = half[A_BIT];
  assign d_w  = half[W_BIT];
  assign d_s  = half[S_BIT];
  assign d_c  = half[C_BIT];
  assign take = !mem_nxm && d_a && (!q_write || d_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      q_vpn        <= '0;
      q_user       <= 1'b0;
      q_write      <= 1'b0;
      q_query      <= 1'b0;
      mem_addr     <= '0;
      done         <= 1'b0;
      ok           <= 1'b0;
      fault        <= 1'b0;
      hard         <= 1'b0;
      entry_ppn    <= '0;
      entry_valid  <= 1'b0;
      entry_modify <= 1'b0;
      tbl_we       <= 1'b0;
      fsw          <= '0;
    end else begin
      done   <= 1'b0;
      tbl_we <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          q_vpn    <= req_vpn;
          q_user   <= req_user;
          q_write  <= req_write;
          q_query  <= req_query;
          mem_addr <= desc_addr;
          st       <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          st           <= S_IDLE;
          done         <= 1'b1;
          ok           <= take;
          fault        <= !take;
          hard         <= mem_nxm;
          entry_valid  <= take;
          entry_ppn    <= take ? half[PPN_W-1:0] : '0;
          entry_modify <= take && d_w;
          tbl_we       <= take && !q_query;
          fsw          <= {mem_nxm,
                           !mem_nxm && q_query && d_c,
                           !mem_nxm && (d_a || q_query) && d_s,
                           !mem_nxm && q_query && d_w,
                           !mem_nxm && d_a,
                           q_write, q_user, q_vpn};
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pmap_walker_chk.sv
module pmap_walker_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              done,
  input logic              ok,
  input logic              fault,
  input logic              hard,
  input logic              entry_valid,
  input logic              entry_modify,
  input logic              tbl_we,
  input logic              q_write,
  input logic              q_query
);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req);

  // R11
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> $stable(mem_addr));

  // R11
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> done);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  // R6
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok != fault));

  // R7
  entry_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (entry_valid == ok));

  // R7
  write_modify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok && q_write |-> entry_modify);

  // R9
  query_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> done && ok && !q_query);

  // R10
  hard_is_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && hard |-> fault && !tbl_we);

endmodule

bind pmap_walker pmap_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .done(done), .ok(ok),
  .fault(fault), .hard(hard), .entry_valid(entry_valid),
  .entry_modify(entry_modify), .tbl_we(tbl_we), .q_write(q_write),
  .q_query(q_query)
);

// File: tb/pmap_walker_tb.sv
module pmap_walker_tb;
  localparam int VPN_W = 9;
  localparam int AW    = 16;
  localparam int PW    = 8;
  localparam int FW    = VPN_W + 7;
  localparam logic [AW-1:0] UMAP = 16'o200, SLO = 16'o1000, SMID = 16'o700, SHI = 16'o1200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_user = 1'b0, req_write = 1'b0, req_query = 1'b0;
  logic [VPN_W-1:0] req_vpn = '0;
  logic [AW-1:0] user_base = 16'hFF40, sup_base = 16'hFE90;
  logic mem_req, mem_ack = 1'b0, mem_nxm = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [35:0] mem_rdata = '0;
  logic done, ok, fault, hard, entry_valid, entry_modify, tbl_we;
  logic [PW-1:0] entry_ppn;
  logic [FW-1:0] fsw;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  pmap_walker #(.VPN_W(VPN_W), .ADDR_W(AW), .PPN_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_user(req_user), .req_write(req_write), .req_query(req_query),
    .user_base(user_base), .sup_base(sup_base), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_nxm(mem_nxm), .done(done), .ok(ok),
    .fault(fault), .hard(hard), .entry_ppn(entry_ppn), .entry_valid(entry_valid),
    .entry_modify(entry_modify), .tbl_we(tbl_we), .fsw(fsw));

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] hw(input logic [AW-1:0] a, input int s);
    logic [15:0] x;
    x = 16'(a * 5 + s * 3);
    return {x[3:0], 14'(x * 7)};
  endfunction

  function automatic logic [AW-1:0] exp_addr(input bit u, input int v);
    if (u) return user_base + UMAP + AW'(v >> 1);
    if (v < 'o340) return sup_base + SLO + AW'(v >> 1);
    if (v < 'o400) return user_base + SMID + AW'((v - 'o340) >> 1);
    return sup_base + SHI + AW'((v - 'o400) >> 1);
  endfunction

  task automatic walk(input bit u, input int v, input bit wr, input bit q, input bit nxm, input int dly);
    logic [AW-1:0] ea;
    logic [17:0] h;
    string rt;
    bit a, w, s, c, g;
    ea = exp_addr(u, v);
    rt = u ? "R1" : (v < 'o340) ? "R2" : (v < 'o400) ? "R3" : "R4";
    @(negedge clk);
    req_valid = 1'b1; req_user = u; req_vpn = VPN_W'(v); req_write = wr; req_query = q;
    @(negedge clk);
    req_valid = 1'b0;
    cmp({rt, " descriptor address"}, 64'(mem_addr), 64'(ea));
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      cmp("R11 request held with stable address", 64'({mem_req, mem_addr}), 64'({1'b1, ea}));
    end
    mem_ack = 1'b1; mem_nxm = nxm;
    mem_rdata = {hw(mem_addr, 0), hw(mem_addr, 1)};
    @(negedge clk);
    mem_ack = 1'b0; mem_nxm = 1'b0;
    h = (v % 2 == 1) ? hw(ea, 1) : hw(ea, 0);
    a = h[17]; w = h[16]; s = h[15]; c = h[14];
    g = !nxm && a && (!wr || w);
    cmp("R11 done one cycle after ack", 64'(done), 64'd1);
    if (nxm) begin
      cmp("R10 hard fault outcome", 64'({ok, fault, hard, tbl_we, entry_valid}), 64'(5'b01100));
      cmp("R10 hard fault status word", 64'(fsw), 64'({1'b1, 4'b0, wr, u, VPN_W'(v)}));
    end else begin
      cmp("R6 grant decision", 64'({ok, fault}), 64'({g, !g}));
      cmp("R5 halfword page select", 64'(entry_ppn), 64'(g ? h[PW-1:0] : '0));
      cmp("R7 entry valid and modify", 64'({entry_valid, entry_modify}), 64'({g, g && w}));
      cmp(q ? "R9 query status word" : "R8 status word", 64'(fsw),
          64'({1'b0, q && c, (a || q) && s, q && w, a, wr, u, VPN_W'(v)}));
      cmp("R9 table update enable", 64'(tbl_we), 64'(g && !q));
    end
    @(negedge clk);
    cmp("R11 done is a single pulse", 64'({done, req_ready}), 64'(2'b01));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R12 reset state", 64'({req_ready, mem_req, done, ok, fault, hard, tbl_we}), 64'(7'b1000000));
    for (int u = 0; u < 2; u++)
      for (int v = 0; v < 512; v++)
        for (int m = 0; m < 4; m++)
          walk(u[0], v, m[0], m[1], 1'b0, (v + m) % 3);
    for (int v = 0; v < 24; v++)
      walk(v[0], v * 21, v[1], v[2], 1'b1, v % 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule